// File: doc/BRIEF.md
# Bus Error Latch and Double-Fault Detector

This block sits beside a small CPU's external bus controller. It watches the terminations of external bus cycles and decides how the CPU responds to a bus error. A bus error is recorded in a sticky flag, but the CPU does not act on it until the instruction in flight completes. At that instruction boundary the block raises a single exception request. However many errors the instruction collected, it raises only one.

Two short windows are treated as fatal. The first runs from the end of reset up to the first instruction. The second runs from the start of bus-error exception processing up to the first instruction of the handler. A bus error inside either window locks the block and enables the active-low HALT driver. Only reset releases this lock. While the block is locked, bus arbitration requests are still granted.

The block also keeps the read-data capture register of the bus interface. Data from a cycle that ends in a bus error is not captured. If that cycle was an instruction prefetch, the register loads all-ones bytes instead.

Top module: `berr_fault_ctl`

## Requirements
- R1: A bus error sets the error flag on the next clock edge without raising the exception request. The request `exc_req_o` is a one-cycle pulse in the cycle after an instruction-boundary pulse, when the flag is set or an ordinary bus error arrives with that boundary.
- R2: Any number of bus errors before one instruction boundary produce exactly one request pulse.
- R3: A first-instruction pulse while the bus-error exception window is open clears the error flag and closes the window.
- R4: A bus error while the bus-error exception window is open (opened by `exc_start_i`) sets `locked_o` and `halt_oe_o` on the next edge.
- R5: The reset window is open when reset is released and closes on the first-instruction pulse. A bus error while it is open locks the block as in R4.
- R6: A bus error outside both windows sets only the error flag and never the lock.
- R7: The lock holds until reset. While locked, `exc_req_o` stays low.
- R8: `arb_gnt_o` equals `arb_req_i` delayed by one clock, whether or not the block is locked.
- R9: On `cyc_end_i` the capture register loads `rdata_i`. If `berr_i` is high, it keeps its value instead, unless `prefetch_i` is high, in which case every byte loads 0xFF.
- R10: An active-low `rst_n` asynchronously clears every output, including the lock and the capture register.
- R11: `exc_start_i` is ignored while the reset window is open or the block is locked, and the two windows are never open together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| berr_i | input | 1 | Bus cycle terminated by bus error |
| insn_done_i | input | 1 | Instruction boundary pulse |
| exc_start_i | input | 1 | Bus-error exception processing begins |
| first_insn_i | input | 1 | First instruction (after reset or of handler) executes |
| arb_req_i | input | 1 | Bus arbitration request |
| cyc_end_i | input | 1 | External read cycle ends |
| prefetch_i | input | 1 | Ending cycle is an instruction prefetch |
| rdata_i | input | DW | Read data from bus |
| exc_req_o | output | 1 | Bus-error exception request pulse |
| err_flag_o | output | 1 | Latched bus-error flag |
| locked_o | output | 1 | Double-fault lock |
| halt_oe_o | output | 1 | Enable for pulling HALT low |
| arb_gnt_o | output | 1 | Arbitration grant |
| cap_data_o | output | DW | Captured read data |

## Verification
The assertions assume that the CPU side sends pulses in a sane order. `exc_start_i` never coincides with `first_insn_i`. No new instruction boundary arrives while an exception window is already open. The stimulus follows a real sequence: a reset, then a first instruction, then error bursts, then a boundary, then exception start, then the handler's first instruction. Each pulse lasts one cycle. Double faults are injected only after a window has been opened through its proper pulse.

// File: rtl/berr_pkg.sv
package berr_pkg;
  localparam int unsigned BYTE_W = 8;

  // all-ones image laid over a given number of bytes
  function automatic logic [63:0] byte_fill(input int unsigned nbytes);
    logic [63:0] v;
    v = '0;
    for (int unsigned i = 0; i < 8; i++)
      if (i < nbytes) v[i*BYTE_W +: BYTE_W] = 8'hFF;
    return v;
  endfunction

  // a bus error is fatal when any guard window is open
  function automatic logic is_double_fault(input logic berr, input logic rwin,
                                           input logic ewin);
    return berr & (rwin | ewin);
  endfunction
endpackage

// File: rtl/berr_windows.sv
module berr_windows (
  input  logic clk,
  input  logic rst_n,
  input  logic exc_start_i,
  input  logic first_insn_i,
  input  logic locked_i,
  output logic rst_win_o,
  output logic exc_win_o
);
  logic rst_win_q, exc_win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_win_q <= 1'b1;
      exc_win_q <= 1'b0;
    end else begin
      if (first_insn_i) rst_win_q <= 1'b0;
      if (first_insn_i)
        exc_win_q <= 1'b0;
      else if (exc_start_i && !rst_win_q && !locked_i)
        exc_win_q <= 1'b1;
    end
  end

  assign rst_win_o = rst_win_q;
  assign exc_win_o = exc_win_q;
endmodule

// File: rtl/berr_latch.sv
module berr_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic berr_i,
  input  logic dfault_i,
  input  logic insn_done_i,
  input  logic first_insn_i,
  input  logic exc_win_i,
  input  logic locked_i,
  output logic flag_o,
  output logic req_o
);
  logic flag_q, req_q;
  logic ord_err;

  assign ord_err = berr_i & ~dfault_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (ord_err && !locked_i)
        flag_q <= 1'b1;
      else if (first_insn_i && exc_win_i)
        flag_q <= 1'b0;
      req_q <= insn_done_i & (flag_q | ord_err) & ~exc_win_i
               & ~locked_i & ~dfault_i;
    end
  end

  assign flag_o = flag_q;
  assign req_o  = req_q;
endmodule

// File: rtl/berr_lock.sv
module berr_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic dfault_i,
  output logic locked_o,
  output logic halt_oe_o
);
  logic locked_q, halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      halt_q   <= 1'b0;
    end else if (dfault_i) begin
      locked_q <= 1'b1;
      halt_q   <= 1'b1;
    end
  end

  assign locked_o  = locked_q;
  assign halt_oe_o = halt_q;
endmodule

// File: rtl/berr_capture.sv
module berr_capture #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_end_i,
  input  logic          berr_i,
  input  logic          prefetch_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] cap_o
);
  import berr_pkg::*;
  localparam int unsigned NBYTES = DW / BYTE_W;
  localparam logic [63:0] FILL64 = byte_fill(NBYTES);
  localparam logic [DW-1:0] FILL = FILL64[DW-1:0];

  logic [DW-1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cap_q <= '0;
    else if (cyc_end_i) begin
      if (!berr_i)
        cap_q <= rdata_i;
      else if (prefetch_i)
        cap_q <= FILL;
    end
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/berr_fault_ctl.sv
module berr_fault_ctl #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          berr_i,
  input  logic          insn_done_i,
  input  logic          exc_start_i,
  input  logic          first_insn_i,
  input  logic          arb_req_i,
  input  logic          cyc_end_i,
  input  logic          prefetch_i,
  input  logic [DW-1:0] rdata_i,
  output logic          exc_req_o,
  output logic          err_flag_o,
  output logic          locked_o,
  output logic          halt_oe_o,
  output logic          arb_gnt_o,
  output logic [DW-1:0] cap_data_o
);
  import berr_pkg::*;

  // named internal events, visible to the bound checker
  logic rst_win, exc_win, dfault_evt, gnt_q;

  assign dfault_evt = is_double_fault(berr_i, rst_win, exc_win) & ~locked_o;

  berr_windows u_win (
    .clk(clk), .rst_n(rst_n), .exc_start_i(exc_start_i),
    .first_insn_i(first_insn_i), .locked_i(locked_o),
    .rst_win_o(rst_win), .exc_win_o(exc_win)
  );

  berr_latch u_latch (
    .clk(clk), .rst_n(rst_n), .berr_i(berr_i), .dfault_i(dfault_evt),
    .insn_done_i(insn_done_i), .first_insn_i(first_insn_i),
    .exc_win_i(exc_win), .locked_i(locked_o),
    .flag_o(err_flag_o), .req_o(exc_req_o)
  );

  berr_lock u_lock (
    .clk(clk), .rst_n(rst_n), .dfault_i(dfault_evt),
    .locked_o(locked_o), .halt_oe_o(halt_oe_o)
  );

  berr_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cyc_end_i(cyc_end_i), .berr_i(berr_i),
    .prefetch_i(prefetch_i), .rdata_i(rdata_i), .cap_o(cap_data_o)
  );

  // arbitration path kept apart from the lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= 1'b0;
    else        gnt_q <= arb_req_i;
  end
  assign arb_gnt_o = gnt_q;
endmodule

// File: rtl/berr_fault_ctl_chk.sv
module berr_fault_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic berr_i,
  input logic insn_done_i,
  input logic first_insn_i,
  input logic arb_req_i,
  input logic exc_req_o,
  input logic err_flag_o,
  input logic locked_o,
  input logic halt_oe_o,
  input logic arb_gnt_o,
  input logic rst_win,
  input logic exc_win
);
  // R1: a request only follows a boundary pulse
  a_r1_req_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> $past(insn_done_i));
  // R2: never two request pulses back to back
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |=> !exc_req_o);
  // R4: a bus error inside the exception window locks and drives HALT
  a_r4_exc_window_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_i && exc_win) |=> (locked_o && halt_oe_o));
  // R5: a bus error inside the reset window locks
  a_r5_reset_window_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_i && rst_win) |=> locked_o);
  // R6: an ordinary bus error leaves the lock alone and sets the flag
  a_r6_ordinary_error: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_i && !rst_win && !exc_win && !locked_o) |=> (err_flag_o && !locked_o));
  // R7: lock is sticky and silences requests
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> (locked_o && !exc_req_o));
  // R8: grant tracks request even when locked
  a_r8_arb_alive: assert property (@(posedge clk) disable iff (!rst_n)
    arb_req_i |=> arb_gnt_o);
  // R11: windows never overlap
  a_r11_windows_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_win && exc_win));
  // R3: first instruction shuts the exception window
  a_r3_window_close: assert property (@(posedge clk) disable iff (!rst_n)
    (first_insn_i && exc_win) |=> !exc_win);
endmodule

bind berr_fault_ctl berr_fault_ctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .berr_i(berr_i), .insn_done_i(insn_done_i),
  .first_insn_i(first_insn_i), .arb_req_i(arb_req_i), .exc_req_o(exc_req_o),
  .err_flag_o(err_flag_o), .locked_o(locked_o), .halt_oe_o(halt_oe_o),
  .arb_gnt_o(arb_gnt_o), .rst_win(rst_win), .exc_win(exc_win)
);

// File: tb/berr_fault_ctl_tb_top.sv
module berr_fault_ctl_tb_top;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic berr_i = 0, insn_done_i = 0, exc_start_i = 0, first_insn_i = 0;
  logic arb_req_i = 0, cyc_end_i = 0, prefetch_i = 0;
  logic [DW-1:0] rdata_i = '0;
  logic exc_req_o, err_flag_o, locked_o, halt_oe_o, arb_gnt_o;
  logic [DW-1:0] cap_data_o;

  always #2 clk = ~clk;

  berr_fault_ctl #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .berr_i(berr_i), .insn_done_i(insn_done_i),
    .exc_start_i(exc_start_i), .first_insn_i(first_insn_i),
    .arb_req_i(arb_req_i), .cyc_end_i(cyc_end_i), .prefetch_i(prefetch_i),
    .rdata_i(rdata_i), .exc_req_o(exc_req_o), .err_flag_o(err_flag_o),
    .locked_o(locked_o), .halt_oe_o(halt_oe_o), .arb_gnt_o(arb_gnt_o),
    .cap_data_o(cap_data_o)
  );

  typedef struct {
    string       req;
    int          sel;
    logic [15:0] val;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  function automatic logic [15:0] probe(input int sel);
    case (sel)
      0: return {15'd0, exc_req_o};
      1: return {15'd0, err_flag_o};
      2: return {15'd0, locked_o};
      3: return {15'd0, halt_oe_o};
      4: return {15'd0, arb_gnt_o};
      default: return cap_data_o;
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        act = probe(it.sel);
        n_chk++;
        if (act !== it.val) begin
          n_err++;
          $display("FAIL %s sig%0d actual=%h expected=%h", it.req, it.sel, act, it.val);
        end
      end
    end
  end

  task automatic expect_v(input string r, input int sel, input logic [15:0] v);
    item_t it;
    it.req = r; it.sel = sel; it.val = v;
    q.push_back(it);
  endtask

  task automatic cyc(input logic b, input logic d, input logic s, input logic f,
                     input logic a, input logic e, input logic p, input logic [15:0] rd);
    @(negedge clk);
    berr_i = b; insn_done_i = d; exc_start_i = s; first_insn_i = f;
    arb_req_i = a; cyc_end_i = e; prefetch_i = p; rdata_i = rd;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 16'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    berr_i = 0; insn_done_i = 0; exc_start_i = 0; first_insn_i = 0;
    arb_req_i = 0; cyc_end_i = 0; prefetch_i = 0;
    rst_n = 0;
    @(posedge clk);
    #1;
    expect_v("R10", 0, 0); expect_v("R10", 1, 0); expect_v("R10", 2, 0);
    expect_v("R10", 3, 0); expect_v("R10", 4, 0); expect_v("R10", 5, 0);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // leave reset window
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    // R1: error latched, no request yet
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    expect_v("R1", 1, 1); expect_v("R1", 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    expect_v("R2", 1, 1);
    // R2: merged request at the boundary
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    expect_v("R2", 0, 1);
    idle();
    expect_v("R2", 0, 0);
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    expect_v("R3", 1, 1); expect_v("R3", 2, 0);
    // R3: first handler instruction clears flag
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    expect_v("R3", 1, 0);
    // R6: error inside handler is ordinary
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    expect_v("R6", 1, 1); expect_v("R6", 2, 0);
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    expect_v("R1", 0, 1);
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    expect_v("R3", 1, 0);
    // R4: double fault in exception window
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    expect_v("R4", 2, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    expect_v("R4", 2, 1); expect_v("R4", 3, 1);
    // R8: arbitration granted while locked
    cyc(0, 0, 0, 0, 1, 0, 0, 0);
    expect_v("R8", 4, 1); expect_v("R7", 2, 1);
    idle();
    expect_v("R8", 4, 0);
    // R7: lock holds, no request
    cyc(1, 1, 0, 0, 0, 0, 0, 0);
    expect_v("R7", 0, 0); expect_v("R7", 2, 1); expect_v("R7", 3, 1);
    do_reset();
    idle();
    expect_v("R7", 2, 0);
    // R11: exception start ignored during reset window
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    expect_v("R11", 2, 0); expect_v("R11", 1, 1);
    // R5: error inside reset window locks
    do_reset();
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    expect_v("R5", 2, 1); expect_v("R5", 3, 1); expect_v("R5", 1, 0);
    do_reset();
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    // R9: capture rules
    cyc(0, 0, 0, 0, 0, 1, 0, 16'hA5A5);
    expect_v("R9", 5, 16'hA5A5);
    cyc(1, 0, 0, 0, 0, 1, 0, 16'h1234);
    expect_v("R9", 5, 16'hA5A5);
    cyc(0, 0, 0, 0, 0, 0, 0, 16'h5555);
    expect_v("R9", 5, 16'hA5A5);
    cyc(1, 0, 0, 0, 0, 1, 1, 16'h1234);
    expect_v("R9", 5, 16'hFFFF);
    idle();
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule